// File: doc/BRIEF.md
# Stepper Driver Chain Serial Link

This block drives a daisy chain of stepper motor driver chips over a three-wire serial link made of chip select, serial clock and data. It builds each datagram when the datagram is sent. A 64-entry bit map decides the datagram's content. Each map entry names one control bit of one motor's 32-bit signal vector, and the vectors arrive as parallel inputs. A flag on an entry moves the selection on to the next motor in the chain.

A host programs the block through a simple write port. Through it the host sets the bit map, the index of the last motor in the chain, four phase lengths and two polarity bits. A start pulse sends one datagram. The data returning from the end of the chain is shifted into a 64-bit readback register on every rising serial clock edge.

Top module: `stepchain_ser`

## Requirements
- R1: Writes with `wr_en` high land on the next clock edge. Addresses 0 to 63 hold map entries: bit 5 is the advance flag and bits 4:0 are the bit code. Address 64 bits 1:0 hold the last-motor index. Addresses 65, 66, 67 and 68 hold the setup, clock-low, clock-high and hold lengths. Address 69 bit 0 inverts chip select and bit 1 inverts the serial clock.
- R2: A data bit is `mot_sig[32*m + code]`, where m is the current motor address and code is the entry's bit code.
- R3: Entries are sent in ascending order from entry 0. The motor address is 0 at the start of every datagram. Each entry after entry 0 that has its flag set adds one to the motor address. The flag on entry 0 is ignored.
- R4: The datagram ends before the first entry whose flag would move the address past the last-motor index. If no such entry exists, it ends after entry 63.
- R5: A datagram lasts setup cycles with the clock inactive. Each bit then takes low cycles followed by high cycles. Hold cycles with the clock inactive close the datagram.
- R6: After reset, all four lengths are 16 cycles, the last-motor index is 0, both polarity bits are 0 and every map entry is 0.
- R7: Chip select is low while busy and high while idle. The serial clock is low while idle and high only in high phases. Each polarity bit inverts its pin.
- R8: `sdo` shows a new bit in the first setup cycle and at the start of every later low phase. It holds that bit through the bit's high phase and through the hold time. `sdo` is 0 while idle.
- R9: At the end of every low phase, `sdi` enters bit 0 of `rdback` and the older bits move up by one.
- R10: A start pulse is taken only when idle. `busy` is high from the first setup cycle to the last hold cycle. `done` is high for the one cycle that follows the last hold cycle.
- R11: A phase length equals the stored value plus 1. A stored value below 7 counts as 7, so each phase lasts 8 to 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Datagram start pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| mot_sig | input | 128 | Four 32-bit motor signal vectors, motor 0 in the low bits |
| sdi | input | 1 | Serial data returning from the chain |
| csn | output | 1 | Chip select pin |
| sck | output | 1 | Serial clock pin |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Datagram in progress |
| done | output | 1 | One-cycle end-of-datagram pulse |
| rdback | output | 64 | Readback shift register |

## Verification
The assertions assume that the polarity register and the last-motor index change only while the block is idle. A change during a datagram would move a pin or the address in ways that the edge rules do not cover. The bench performs every configuration write between datagrams, and it holds `mot_sig` steady while a datagram runs. It also raises `start` in the middle of one datagram to show that the pulse is ignored.

// File: rtl/stepchain_ser.sv
module stepchain_ser #(
  parameter int MW = 2,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH):0]   wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [(32<<MW)-1:0]      mot_sig,
  input  logic                     sdi,
  output logic                     csn,
  output logic                     sck,
  output logic                     sdo,
  output logic                     busy,
  output logic                     done,
  output logic [DEPTH-1:0]         rdback
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] A_LAST = (AW+1)'(DEPTH);
  localparam logic [AW:0] A_TIM  = (AW+1)'(DEPTH + 1);
  localparam logic [AW:0] A_POL  = (AW+1)'(DEPTH + 5);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD} st_t;
  st_t st;

  logic [5:0]    ram [DEPTH];
  logic [7:0]    tcfg [4];
  logic [MW-1:0] last, mot;
  logic [1:0]    pol;
  logic [AW-1:0] ent;
  logic [7:0]    cnt;
  logic          sdo_r, done_r;
  logic [DEPTH-1:0] rb;

  function automatic logic [7:0] ld(input logic [7:0] v);
    return (v < 8'd7) ? 8'd7 : v;
  endfunction

  wire [AW-1:0] ent_n   = ent + 1'b1;
  wire          adv_n   = ram[ent_n][5];
  wire          is_last = (ent == AW'(DEPTH - 1)) || (adv_n && mot == last);
  wire [MW-1:0] mot_n   = adv_n ? mot + 1'b1 : mot;
  wire [AW:0]   tim_off = wr_addr - A_TIM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
      for (int k = 0; k < 4; k++) tcfg[k] <= 8'd15;
      last <= '0;
      pol  <= '0;
    end else if (wr_en) begin
      if (!wr_addr[AW]) ram[wr_addr[AW-1:0]] <= wr_data[5:0];
      else if (wr_addr == A_LAST) last <= wr_data[MW-1:0];
      else if (wr_addr == A_POL) pol <= wr_data[1:0];
      else if (wr_addr >= A_TIM && wr_addr < A_POL) tcfg[tim_off[1:0]] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ent <= '0;
      mot <= '0;
      sdo_r <= 1'b0;
      done_r <= 1'b0;
      rb <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_SETUP;
            cnt <= ld(tcfg[0]);
            ent <= '0;
            mot <= '0;
            sdo_r <= mot_sig[{MW'(0), ram[0][4:0]}];
          end
        S_SETUP:
          if (cnt == 0) begin
            st <= S_LOW;
            cnt <= ld(tcfg[1]);
          end else cnt <= cnt - 1'b1;
        S_LOW:
          if (cnt == 0) begin
            st <= S_HIGH;
            cnt <= ld(tcfg[2]);
            rb <= {rb[DEPTH-2:0], sdi};
          end else cnt <= cnt - 1'b1;
        S_HIGH:
          if (cnt == 0) begin
            if (is_last) begin
              st <= S_HOLD;
              cnt <= ld(tcfg[3]);
            end else begin
              st <= S_LOW;
              cnt <= ld(tcfg[1]);
              ent <= ent_n;
              mot <= mot_n;
              sdo_r <= mot_sig[{mot_n, ram[ent_n][4:0]}];
            end
          end else cnt <= cnt - 1'b1;
        S_HOLD:
          if (cnt == 0) begin
            st <= S_IDLE;
            done_r <= 1'b1;
            sdo_r <= 1'b0;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  assign busy   = (st != S_IDLE);
  assign csn    = (st == S_IDLE) ^ pol[0];
  assign sck    = (st == S_HIGH) ^ pol[1];
  assign sdo    = sdo_r;
  assign done   = done_r;
  assign rdback = rb;
endmodule

module stepchain_ser_chk #(
  parameter int MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          csn,
  input logic          sck,
  input logic          sdo,
  input logic [1:0]    pol,
  input logic [MW-1:0] mot,
  input logic [MW-1:0] last
);
  wire sck_eff = sck ^ pol[1];

  // R10
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csn == !pol[0] && sck == pol[1]));
  // R7
  active_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> csn == pol[0]);
  // R8
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sdo != $past(sdo)) |-> (!sck_eff && $past(sck_eff)));
  // R8
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sdo);
  // R4
  mot_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> mot <= last);
endmodule

bind stepchain_ser stepchain_ser_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .csn(csn), .sck(sck),
  .sdo(sdo), .pol(pol), .mot(mot), .last(last)
);

// File: tb/sim_stepchain_ser.sv
`timescale 1ns/1ps
module sim_stepchain_ser;
  logic clk = 0, rst_n = 0, start = 0, wr_en = 0, sdi = 0;
  logic [6:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [127:0] sig = 0;
  wire csn, sck, sdo, busy, done;
  wire [63:0] rdback;

  always #4 clk = ~clk;

  stepchain_ser u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mot_sig(sig), .sdi(sdi), .csn(csn), .sck(sck), .sdo(sdo),
    .busy(busy), .done(done), .rdback(rdback)
  );

  typedef struct packed {logic busy, csn, sck, sdo, done, shift;} ex_t;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [5:0] mram [64];
  logic [1:0] mlast = 0, mpol = 0;
  int mlen [4];
  logic [63:0] rb_exp = 0;
  ex_t exq[$];
  bit bq[$];

  function automatic int plen(input logic [7:0] v);
    return (v < 8'd7) ? 8 : int'(v) + 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R1: write through the port, mirrored in the model
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[6:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 0;
    if (a < 64) mram[a] = d[5:0];
    else if (a == 64) mlast = d[1:0];
    else if (a < 69) mlen[a-65] = plen(d[7:0]);
    else if (a == 69) mpol = d[1:0];
  endtask

  task automatic build();
    int m;
    logic act, idl, lo, hi, b;
    bq.delete(); exq.delete();
    m = 0;
    for (int e = 0; e < 64; e++) begin
      if (e > 0 && mram[e][5]) begin
        if (m == int'(mlast)) break;
        m++;
      end
      bq.push_back(sig[m*32 + int'(mram[e][4:0])]);
    end
    act = mpol[0]; idl = ~mpol[0]; lo = mpol[1]; hi = ~mpol[1];
    for (int j = 0; j < mlen[0]; j++) exq.push_back({1'b1, act, lo, bq[0], 1'b0, 1'b0});
    foreach (bq[i]) begin
      b = bq[i];
      for (int j = 0; j < mlen[1]; j++) exq.push_back({1'b1, act, lo, b, 1'b0, j == mlen[1]-1});
      for (int j = 0; j < mlen[2]; j++) exq.push_back({1'b1, act, hi, b, 1'b0, 1'b0});
    end
    b = bq[bq.size()-1];
    for (int j = 0; j < mlen[3]; j++) exq.push_back({1'b1, act, lo, b, 1'b0, 1'b0});
    exq.push_back({1'b0, idl, lo, 1'b0, 1'b1, 1'b0});
    exq.push_back({1'b0, idl, lo, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic run(input bit inject);
    build();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    foreach (exq[i]) begin
      if (i > 0) @(negedge clk);
      chk("R10 busy/done", {busy, done}, {exq[i].busy, exq[i].done});
      chk("R5/R7 csn/sck", {csn, sck}, {exq[i].csn, exq[i].sck});
      chk("R2/R3/R4/R8 sdo", sdo, exq[i].sdo);
      start = inject && (i == 10);
      sdi = 1'($urandom);
      if (exq[i].shift) rb_exp = {rb_exp[62:0], sdi};
    end
    chk("R9 rdback", rdback, rb_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mlen[k] = 16;
    for (int e = 0; e < 64; e++) mram[e] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 reset csn", csn, 1);
    chk("R6 reset sck", sck, 0);
    chk("R6 reset busy/done", {busy, done}, 0);
    chk("R6 reset sdo", sdo, 0);
    chk("R6 reset rdback", rdback, 0);

    // R6 default timing, two motors, stop at next flag (R4)
    sig = 128'hA5C3_0F96_1234_5678_DEAD_BEEF_8001_7FFE;
    wr(0, 3); wr(1, 7); wr(2, 31); wr(3, 32 + 0); wr(4, 12); wr(5, 32 + 9);
    wr(64, 1);
    run(0);

    // R11 clamp, R4 run to entry 63 on the last motor
    sig = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
    wr(0, 1); wr(1, 9); wr(2, 32 + 4); wr(3, 30); wr(4, 32 + 17); wr(5, 2);
    wr(6, 32 + 31); wr(7, 0);
    wr(64, 3); wr(65, 7); wr(66, 2); wr(67, 7); wr(68, 200);
    run(0);

    // R7 both pins inverted, R11 longest setup, R10 start during busy ignored
    sig = 128'hFFFF_0000_5555_AAAA_3333_CCCC_0F0F_F0F0;
    wr(69, 3); wr(65, 255); wr(64, 0); wr(0, 6); wr(1, 32 + 5);
    run(1);

    // R3 flag on entry 0 ignored, three motors; R7 clock inverted only
    sig = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;
    wr(69, 2); wr(65, 15); wr(68, 9); wr(64, 2);
    wr(0, 32 + 3); wr(1, 32 + 7); wr(2, 32 + 20); wr(3, 32 + 1);
    run(0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule